// File: doc/BRIEF.md
# Dual AGC Parallel Output Formatter

This block places gain-controlled I/Q samples from two automatic gain control sources, A and B, onto one 16-bit parallel output port. Each source delivers a sample as an I/Q pair with a strobe, and separately reports each new 12-bit gain word with an update strobe. A per-source enable decides whether that source's samples are taken in at all. A sample that has not been sent waits in a one-deep holding register. A newer sample from the same source replaces it.

The port uses a request/acknowledge handshake. The block raises its request while it is idle and an enabled source holds a sample. A downstream reader answers with acknowledge. The accepted transfer is then a burst: an I word, then a Q word. When that source's gain changed since its previous transfer, a third word follows that carries a signal-strength value. This value is the bitwise complement of the current gain word. A 2-bit tag names the source and the kind of word, and an I/Q indicator marks the I word.

Top module: `agc_port_fmt`

## Requirements
- R1: After reset `req_o`, `iq_o`, `tag_o` and `data_o` are all zero.
- R2: A sample strobe from a source is captured only while that source's enable is 1. A strobe from a disabled source is ignored. `req_o` is 1 in the cycle after capture, for as long as the block is idle and an enabled source holds a sample.
- R3: On the clock edge where `req_o` and `ack_i` are both 1, the block shows the held I word with `iq_o`=1. On the next edge it shows the Q word with `iq_o`=0. Both words carry `tag_o[1]`=0 and `tag_o[0]`=source (0 for A, 1 for B). `ack_i` while `req_o` is 0 has no effect.
- R4: If the source's gain was updated since its last accepted transfer, the edge after the Q word shows a signal-strength word. `data_o[15:4]` holds the bitwise inverse of the latest gain word, `data_o[3:0]`=0, `tag_o`={1, source} and `iq_o`=0.
- R5: If the gain was not updated, no signal-strength word follows the Q word. The changed flag clears when a transfer is accepted, so the next transfer carries no signal-strength word unless the gain is updated again.
- R6: When both sources hold samples, source A is transferred before source B.
- R7: An unsent sample is replaced by a newer sample from the same source, and only the newest is sent, once.
- R8: `req_o` is 0 throughout a burst. After the last word of a burst the port shows `data_o`=0, `tag_o`=0 and `iq_o`=0 for at least one cycle.
- R9: The gain-changed flags of the two sources are independent. A gain update on one source never adds a signal-strength word to the other's transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_a_i | input | 1 | Include source A samples |
| en_b_i | input | 1 | Include source B samples |
| a_vld_i | input | 1 | Source A sample strobe |
| a_i_i | input | 16 | Source A I word |
| a_q_i | input | 16 | Source A Q word |
| a_gain_upd_i | input | 1 | Source A gain update strobe |
| a_gain_i | input | 12 | Source A gain word |
| b_vld_i | input | 1 | Source B sample strobe |
| b_i_i | input | 16 | Source B I word |
| b_q_i | input | 16 | Source B Q word |
| b_gain_upd_i | input | 1 | Source B gain update strobe |
| b_gain_i | input | 12 | Source B gain word |
| ack_i | input | 1 | Reader acknowledge |
| req_o | output | 1 | Data available request |
| data_o | output | 16 | Port data |
| iq_o | output | 1 | High during the I word |
| tag_o | output | 2 | Bit 0 source, bit 1 signal-strength word flag |

## Verification
A sample strobe seen at one rising edge raises `req_o` in the cycle that follows. After the edge that accepts a handshake, the I word is due on that same edge, the Q word one edge later, and the optional signal-strength word two edges later. The port then shows idle on the next edge. The bench drives every input on falling edges and reads each result at the falling edge that follows the rising edge where it is due, one check per word. It sweeps all sixteen combinations of the two enables and the two gain-update strobes. A reference model tracks the held samples and the changed flags, so that state left over from earlier iterations is also predicted.

// File: rtl/agc_fmt_pkg.sv
package agc_fmt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_I    = 2'd1,
    ST_Q    = 2'd2,
    ST_RSSI = 2'd3
  } fmt_state_e;

  localparam int unsigned TAG_W  = 2;
  localparam int unsigned TAG_SRC = 0;
  localparam int unsigned TAG_KIND = 1;
endpackage

// File: rtl/agc_src_hold.sv
module agc_src_hold #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned GAIN_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] i_word_i,
  input  logic [DATA_W-1:0] q_word_i,
  input  logic              gain_upd_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic              take_i,
  output logic              pend_o,
  output logic [DATA_W-1:0] i_word_o,
  output logic [DATA_W-1:0] q_word_o,
  output logic              chg_o,
  output logic [GAIN_W-1:0] gain_o
);
  logic capture;
  assign capture = vld_i && en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o   <= 1'b0;
      i_word_o <= '0;
      q_word_o <= '0;
    end else begin
      // a fresh sample wins over a same-cycle take
      if (capture) begin
        pend_o   <= 1'b1;
        i_word_o <= i_word_i;
        q_word_o <= q_word_i;
      end else if (take_i) begin
        pend_o <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chg_o  <= 1'b0;
      gain_o <= '0;
    end else begin
      if (gain_upd_i) begin
        chg_o  <= 1'b1;
        gain_o <= gain_i;
      end else if (take_i) begin
        chg_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/agc_port_arb.sv
module agc_port_arb #(
  parameter int unsigned N_SRC = 2,
  localparam int unsigned SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] ready_i,
  output logic             any_o,
  output logic [SEL_W-1:0] sel_o
);
  // lowest index has highest priority
  always_comb begin
    sel_o = '0;
    for (int k = N_SRC - 1; k >= 0; k--) begin
      if (ready_i[k]) sel_o = SEL_W'(k);
    end
  end
  assign any_o = |ready_i;
endmodule

// File: rtl/agc_port_seq.sv
module agc_port_seq
  import agc_fmt_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned GAIN_W = 12,
  parameter int unsigned SEL_W  = 1,
  localparam int unsigned PAD_W = DATA_W - GAIN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ack_i,
  input  logic              any_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] sel_i_word_i,
  input  logic [DATA_W-1:0] sel_q_word_i,
  input  logic              sel_chg_i,
  input  logic [GAIN_W-1:0] sel_gain_i,
  output logic              req_o,
  output logic              take_o,
  output logic [DATA_W-1:0] data_o,
  output logic              iq_o,
  output logic [TAG_W-1:0]  tag_o
);
  fmt_state_e        state_q;
  logic [SEL_W-1:0]  src_q;
  logic [DATA_W-1:0] q_word_q;
  logic              rssi_q;
  logic [GAIN_W-1:0] rssi_val_q;

  assign req_o  = (state_q == ST_IDLE) && any_i;
  assign take_o = req_o && ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      src_q      <= '0;
      q_word_q   <= '0;
      rssi_q     <= 1'b0;
      rssi_val_q <= '0;
      data_o     <= '0;
      iq_o       <= 1'b0;
      tag_o      <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (take_o) begin
            src_q      <= sel_i;
            q_word_q   <= sel_q_word_i;
            rssi_q     <= sel_chg_i;
            rssi_val_q <= ~sel_gain_i;
            data_o     <= sel_i_word_i;
            iq_o       <= 1'b1;
            tag_o      <= {1'b0, sel_i[0]};
            state_q    <= ST_I;
          end
        end
        ST_I: begin
          data_o  <= q_word_q;
          iq_o    <= 1'b0;
          state_q <= ST_Q;
        end
        ST_Q: begin
          if (rssi_q) begin
            data_o  <= {rssi_val_q, {PAD_W{1'b0}}};
            tag_o   <= {1'b1, src_q[0]};
            state_q <= ST_RSSI;
          end else begin
            data_o  <= '0;
            tag_o   <= '0;
            state_q <= ST_IDLE;
          end
        end
        default: begin
          data_o  <= '0;
          tag_o   <= '0;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/agc_port_fmt.sv
module agc_port_fmt
  import agc_fmt_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned GAIN_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_a_i,
  input  logic              en_b_i,
  input  logic              a_vld_i,
  input  logic [DATA_W-1:0] a_i_i,
  input  logic [DATA_W-1:0] a_q_i,
  input  logic              a_gain_upd_i,
  input  logic [GAIN_W-1:0] a_gain_i,
  input  logic              b_vld_i,
  input  logic [DATA_W-1:0] b_i_i,
  input  logic [DATA_W-1:0] b_q_i,
  input  logic              b_gain_upd_i,
  input  logic [GAIN_W-1:0] b_gain_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [DATA_W-1:0] data_o,
  output logic              iq_o,
  output logic [TAG_W-1:0]  tag_o
);
  localparam int unsigned N_SRC = 2;
  localparam int unsigned SEL_W = 1;

  logic [N_SRC-1:0]             en_v, vld_v, upd_v, pend_v, chg_v, ready_v;
  logic [N_SRC-1:0][DATA_W-1:0] in_i_v, in_q_v, hold_i_v, hold_q_v;
  logic [N_SRC-1:0][GAIN_W-1:0] in_gain_v, gain_v;
  logic                         any, take;
  logic [SEL_W-1:0]             sel;

  assign en_v      = {en_b_i, en_a_i};
  assign vld_v     = {b_vld_i, a_vld_i};
  assign upd_v     = {b_gain_upd_i, a_gain_upd_i};
  assign in_i_v    = {b_i_i, a_i_i};
  assign in_q_v    = {b_q_i, a_q_i};
  assign in_gain_v = {b_gain_i, a_gain_i};

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    agc_src_hold #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_hold (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en_v[g]),
      .vld_i     (vld_v[g]),
      .i_word_i  (in_i_v[g]),
      .q_word_i  (in_q_v[g]),
      .gain_upd_i(upd_v[g]),
      .gain_i    (in_gain_v[g]),
      .take_i    (take && (sel == SEL_W'(g))),
      .pend_o    (pend_v[g]),
      .i_word_o  (hold_i_v[g]),
      .q_word_o  (hold_q_v[g]),
      .chg_o     (chg_v[g]),
      .gain_o    (gain_v[g])
    );
    assign ready_v[g] = pend_v[g] && en_v[g];
  end

  agc_port_arb #(.N_SRC(N_SRC)) u_arb (
    .ready_i(ready_v),
    .any_o  (any),
    .sel_o  (sel)
  );

  agc_port_seq #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .SEL_W(SEL_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ack_i       (ack_i),
    .any_i       (any),
    .sel_i       (sel),
    .sel_i_word_i(hold_i_v[sel]),
    .sel_q_word_i(hold_q_v[sel]),
    .sel_chg_i   (chg_v[sel]),
    .sel_gain_i  (gain_v[sel]),
    .req_o       (req_o),
    .take_o      (take),
    .data_o      (data_o),
    .iq_o        (iq_o),
    .tag_o       (tag_o)
  );
endmodule

// File: rtl/agc_port_fmt_chk.sv
module agc_port_fmt_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ack_i,
  input logic              req_o,
  input logic [DATA_W-1:0] data_o,
  input logic              iq_o,
  input logic [1:0]        tag_o
);
  // R3
  handshake_gives_i_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && ack_i |=> iq_o && !tag_o[1]);

  // R3
  i_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iq_o |=> !iq_o && !tag_o[1] && $stable(tag_o[0]));

  // R4
  rssi_after_q_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_o[1] |-> $past(iq_o, 2) && !iq_o && data_o[3:0] == 4'd0);

  // R8
  no_req_in_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iq_o || tag_o[1]) |-> !req_o);

  // R8
  idle_after_rssi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_o[1] |=> tag_o == 2'b00 && data_o == '0 && !iq_o);
endmodule

bind agc_port_fmt agc_port_fmt_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .ack_i (ack_i),
  .req_o (req_o),
  .data_o(data_o),
  .iq_o  (iq_o),
  .tag_o (tag_o)
);

// File: tb/agc_port_fmt_test.sv
module agc_port_fmt_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_a_i = 1'b0, en_b_i = 1'b0;
  logic        a_vld_i = 1'b0, b_vld_i = 1'b0;
  logic [15:0] a_i_i = '0, a_q_i = '0, b_i_i = '0, b_q_i = '0;
  logic        a_gain_upd_i = 1'b0, b_gain_upd_i = 1'b0;
  logic [11:0] a_gain_i = '0, b_gain_i = '0;
  logic        ack_i = 1'b0;
  logic        req_o, iq_o;
  logic [15:0] data_o;
  logic [1:0]  tag_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // reference model
  bit          m_chg [2];
  logic [11:0] m_gain [2];
  bit          m_pend [2];
  logic [15:0] m_i [2], m_q [2];

  always #4 clk_i = ~clk_i;

  agc_port_fmt uut (.*);

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic push(input bit sa, input bit sb, input logic [15:0] base);
    @(negedge clk_i);
    a_vld_i = sa; a_i_i = base + 16'h0011; a_q_i = base + 16'h0022;
    b_vld_i = sb; b_i_i = base + 16'h8033; b_q_i = base + 16'h8044;
    if (sa && en_a_i) begin m_pend[0] = 1; m_i[0] = a_i_i; m_q[0] = a_q_i; end
    if (sb && en_b_i) begin m_pend[1] = 1; m_i[1] = b_i_i; m_q[1] = b_q_i; end
    @(negedge clk_i);
    a_vld_i = 0; b_vld_i = 0;
  endtask

  task automatic gains(input bit ua, input bit ub, input int seed);
    @(negedge clk_i);
    a_gain_upd_i = ua; a_gain_i = 12'((seed * 37 + 5) % 4096);
    b_gain_upd_i = ub; b_gain_i = 12'((seed * 91 + 700) % 4096);
    if (ua) begin m_chg[0] = 1; m_gain[0] = a_gain_i; end
    if (ub) begin m_chg[1] = 1; m_gain[1] = b_gain_i; end
    @(negedge clk_i);
    a_gain_upd_i = 0; b_gain_upd_i = 0;
  endtask

  // expects req_o high and source s selected
  task automatic xfer(input int s);
    bit r = m_chg[s];
    ack_i = 1;
    @(negedge clk_i);
    ack_i = 0;
    chk(iq_o === 1'b1 && data_o === m_i[s] && tag_o === {1'b0, 1'(s)}, "R3 I word",
        {data_o, 13'd0, iq_o, tag_o}, {m_i[s], 13'd0, 1'b1, 1'b0, 1'(s)});
    chk(req_o === 1'b0, "R8 req low in burst", req_o, 0);
    @(negedge clk_i);
    chk(iq_o === 1'b0 && data_o === m_q[s] && tag_o === {1'b0, 1'(s)}, "R3 Q word",
        {data_o, 13'd0, iq_o, tag_o}, {m_q[s], 13'd0, 1'b0, 1'b0, 1'(s)});
    @(negedge clk_i);
    if (r) begin
      chk(data_o === {~m_gain[s], 4'h0} && tag_o === {1'b1, 1'(s)} && iq_o === 1'b0,
          "R4 RSSI word", {data_o, tag_o}, {~m_gain[s], 4'h0, 1'b1, 1'(s)});
      @(negedge clk_i);
    end
    chk(data_o === 16'h0 && tag_o === 2'b00 && iq_o === 1'b0, r ? "R8 idle after RSSI" : "R5 no RSSI",
        {data_o, tag_o}, 0);
    m_chg[s] = 0; m_pend[s] = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    for (int s = 0; s < 2; s++) begin m_chg[s] = 0; m_gain[s] = 0; m_pend[s] = 0; end
    repeat (3) @(negedge clk_i);
    chk(req_o === 0 && iq_o === 0 && tag_o === 0 && data_o === 0, "R1 reset state",
        {data_o, iq_o, req_o, tag_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    ack_i = 1;
    @(negedge clk_i);
    ack_i = 0;
    chk(data_o === 0 && iq_o === 0, "R3 ack without req ignored", data_o, 0);

    // sweep enables x gain updates; R2 R6 R9
    for (int k = 0; k < 16; k++) begin
      en_a_i = k[0]; en_b_i = k[1];
      gains(k[2], k[3], k);
      push(1, 1, 16'(k * 256));
      chk(req_o === (m_pend[0] | m_pend[1]), "R2 req after capture", req_o, m_pend[0] | m_pend[1]);
      for (int s = 0; s < 2; s++) if (m_pend[s]) xfer(s);  // R6 A first
      chk(req_o === 0, "R2 no stray request", req_o, 0);
    end

    // R5 flag cleared after sending
    en_a_i = 1; en_b_i = 1;
    gains(1, 0, 99);
    push(1, 0, 16'h1200); xfer(0);
    push(1, 0, 16'h1300); xfer(0);

    // R9 update on B only, transfer A
    gains(0, 1, 55);
    push(1, 0, 16'h1400); xfer(0);
    chk(req_o === 0, "R9 B untouched", req_o, 0);
    push(0, 1, 16'h1500); xfer(1);

    // R7 overwrite before send
    push(1, 0, 16'h2000);
    push(1, 0, 16'h3000);
    chk(m_i[0] == 16'h3011, "R7 model newest", m_i[0], 16'h3011);
    xfer(0);
    chk(req_o === 0, "R7 sent once", req_o, 0);

    // R2 disabled source strobe ignored, then enabling shows nothing pending
    en_b_i = 0;
    push(0, 1, 16'h4000);
    chk(req_o === 0, "R2 disabled ignored", req_o, 0);
    en_b_i = 1;
    @(negedge clk_i);
    chk(req_o === 0, "R2 nothing held after enable", req_o, 0);

    report();
  end
endmodule